// File: doc/BRIEF.md
# RGB555 to Vector Color Converter

This block sits inside a coprocessor register file and converts between a packed 15-bit color word and three signed 16-bit vector registers. A write to the packed word splits it into three 5-bit channels and scales each one into its vector register. The vector registers can also be written directly, which is how arithmetic results reach them.

The packed view is produced from the vector registers on every cycle. Each vector value is scaled down to 5 bits and clamped. Both the packed input word and the packed output word show this collapsed value, so neither one keeps a copy of what was written.

Expansion is not instant. Each channel passes through a short delay pipeline before its vector register changes, and the delay is different per channel. A direct write to a register cancels any expansion still in flight for that register only.

Top module: `rgbvc_top`

## Requirements
- R1: The packed word places red in bits 4:0, green in bits 9:5 and blue in bits 14:10. Bits 31:15 of both packed read ports are always zero. Bits 31:15 of a packed write have no effect.
- R2: A packed write stores channel×0x80 into the matching vector register: red into register 0, green into register 1 and blue into register 2. The stored values lie in 0x0000..0x0F80.
- R3: For a vector value v in 0..0x0FFF, its packed read channel equals v divided by 0x80, rounded down.
- R4: A negative vector value reads back as channel 0. A value of 0x1000..0x7FFF reads back as 0x1F.
- R5: The packed input read port and the packed output read port always carry the same value, which follows the current vector registers.
- R6: A packed write sampled at clock edge N updates register 2 (blue) at edge N+2. Before that edge, register 2 keeps its old value.
- R7: A packed write sampled at edge N updates registers 0 and 1 (red, green) at edge N+3. Before that edge, both keep their old values.
- R8: A direct write to register i (enable bit i) stores data bits 15:0 at the same edge. The register reads back sign-extended to 32 bits, and data bits 31:16 are ignored.
- R9: A direct write to a register cancels any expansion that is pending for it, including one sampled at the same edge. Expansions pending for the other registers still complete.
- R10: After synchronous reset, all vector registers and both packed read ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_wr_en | input | 1 | Packed color write strobe |
| pk_wr_data | input | 32 | Packed color write data |
| vec_wr_en | input | 3 | Per-register direct write enables (bit i selects register i) |
| vec_wr_data | input | 32 | Direct write data; bits 15:0 are used |
| pk_in_rd | output | 32 | Read view of the packed input word |
| pk_out_rd | output | 32 | Read view of the packed output word |
| vec0_rd | output | 32 | Register 0, sign-extended |
| vec1_rd | output | 32 | Register 1, sign-extended |
| vec2_rd | output | 32 | Register 2, sign-extended |

## Verification
The latency properties are checked only when no reset and no direct write to the same register fall inside the window. Outside those conditions the expected value is not defined by R6 and R7.

The direct-write property assumes that the previous cycle was not in reset. The clamping properties assume nothing about the inputs.

The stimulus follows these rules. Reset is held only at the start, and packed sweeps run with direct writes held low. Direct writes are mixed into in-flight expansions only in the dedicated override sequences, whose expected values come from R9.

// File: rtl/rgbvc_pkg.sv
package rgbvc_pkg;

    localparam int NUM_CH    = 3;
    localparam int CH_W      = 5;
    localparam int VEC_W     = 16;
    localparam int WORD_W    = 32;
    localparam int EXP_SHIFT = 7;
    localparam int PACK_W    = NUM_CH * CH_W;

    typedef logic [CH_W-1:0]         chan_t;
    typedef logic signed [VEC_W-1:0] vec_t;
    typedef logic [WORD_W-1:0]       word_t;

    typedef struct packed {
        logic  vld;
        chan_t ch;
    } exp_slot_t;

    function automatic vec_t expand_chan(input chan_t c);
        vec_t r;
        r = '0;
        r[EXP_SHIFT +: CH_W] = c;
        return r;
    endfunction

    function automatic chan_t collapse_vec(input vec_t v);
        if (v[VEC_W-1])
            return '0;
        else if (|v[VEC_W-2:EXP_SHIFT+CH_W])
            return '1;
        else
            return v[EXP_SHIFT +: CH_W];
    endfunction

    function automatic word_t sext_word(input vec_t v);
        return {{(WORD_W-VEC_W){v[VEC_W-1]}}, v};
    endfunction

endpackage

// File: rtl/rgbvc_lane.sv
module rgbvc_lane
    import rgbvc_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  exp_req,
    input  chan_t exp_ch,
    input  logic  dir_we,
    input  vec_t  dir_val,
    output vec_t  vec_q
);

    exp_slot_t slot_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) begin
                slot_q[s] <= '0;
            end
            vec_q <= '0;
        end else begin
            slot_q[0].vld <= exp_req & ~dir_we;
            slot_q[0].ch  <= exp_ch;
            for (int s = 1; s < LAT; s++) begin
                slot_q[s].vld <= slot_q[s-1].vld & ~dir_we;
                slot_q[s].ch  <= slot_q[s-1].ch;
            end
            if (dir_we)
                vec_q <= dir_val;
            else if (slot_q[LAT-1].vld)
                vec_q <= expand_chan(slot_q[LAT-1].ch);
        end
    end

endmodule

// File: rtl/rgbvc_pack.sv
module rgbvc_pack
    import rgbvc_pkg::*;
(
    input  vec_t  vecs [NUM_CH],
    output word_t word
);

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            word[i*CH_W +: CH_W] = collapse_vec(vecs[i]);
        end
    end

endmodule

// File: rtl/rgbvc_top.sv
module rgbvc_top
    import rgbvc_pkg::*;
#(
    parameter int LAT_R = 3,
    parameter int LAT_G = 3,
    parameter int LAT_B = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pk_wr_en,
    input  logic [31:0]       pk_wr_data,
    input  logic [NUM_CH-1:0] vec_wr_en,
    input  logic [31:0]       vec_wr_data,
    output logic [31:0]       pk_in_rd,
    output logic [31:0]       pk_out_rd,
    output logic [31:0]       vec0_rd,
    output logic [31:0]       vec1_rd,
    output logic [31:0]       vec2_rd
);

    vec_t  vec_q [NUM_CH];
    word_t pack_view;
    logic  unused_hi_bits;

    assign unused_hi_bits = ^{pk_wr_data[WORD_W-1:PACK_W], vec_wr_data[WORD_W-1:VEC_W]};

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
            localparam int LAT_I = (i == 0) ? LAT_R : ((i == 1) ? LAT_G : LAT_B);
            rgbvc_lane #(.LAT(LAT_I)) lane_i (
                .clk     (clk),
                .rst     (rst),
                .exp_req (pk_wr_en),
                .exp_ch  (pk_wr_data[i*CH_W +: CH_W]),
                .dir_we  (vec_wr_en[i]),
                .dir_val (vec_wr_data[VEC_W-1:0]),
                .vec_q   (vec_q[i])
            );
        end
    endgenerate

    rgbvc_pack pack_i (
        .vecs (vec_q),
        .word (pack_view)
    );

    assign pk_in_rd  = pack_view;
    assign pk_out_rd = pack_view;
    assign vec0_rd   = sext_word(vec_q[0]);
    assign vec1_rd   = sext_word(vec_q[1]);
    assign vec2_rd   = sext_word(vec_q[2]);

endmodule

// File: rtl/rgbvc_chk.sv
module rgbvc_chk
    import rgbvc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pk_wr_en,
    input logic [31:0]       pk_wr_data,
    input logic [NUM_CH-1:0] vec_wr_en,
    input logic [31:0]       vec_wr_data,
    input logic [31:0]       pk_out_rd,
    input logic [31:0]       vec0_rd,
    input logic [31:0]       vec1_rd,
    input logic [31:0]       vec2_rd
);

    AST_PACK_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        pk_out_rd[WORD_W-1:PACK_W] == '0); // R1

    AST_IN_RANGE_SCALE: assert property (@(posedge clk) disable iff (rst)
        (vec1_rd[WORD_W-1:EXP_SHIFT+CH_W] == '0) |->
        (pk_out_rd[CH_W +: CH_W] == vec1_rd[EXP_SHIFT +: CH_W])); // R3

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst)
        vec0_rd[WORD_W-1] |-> (pk_out_rd[CH_W-1:0] == '0)); // R4

    AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (!vec2_rd[WORD_W-1] && (vec2_rd[VEC_W-2:EXP_SHIFT+CH_W] != '0)) |->
        (pk_out_rd[2*CH_W +: CH_W] == '1)); // R4

    AST_BLUE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ($past(pk_wr_en, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)
         && !$past(vec_wr_en[2], 1) && !$past(vec_wr_en[2], 2) && !$past(vec_wr_en[2], 3))
        |-> (vec2_rd == WORD_W'({$past(pk_wr_data[2*CH_W +: CH_W], 3), EXP_SHIFT'(0)}))); // R6

    AST_RED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ($past(pk_wr_en, 4) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4)
         && !$past(vec_wr_en[0], 1) && !$past(vec_wr_en[0], 2)
         && !$past(vec_wr_en[0], 3) && !$past(vec_wr_en[0], 4))
        |-> (vec0_rd == WORD_W'({$past(pk_wr_data[CH_W-1:0], 4), EXP_SHIFT'(0)}))); // R7

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(vec_wr_en[1]) && !$past(rst)) |->
        (vec1_rd == {{(WORD_W-VEC_W){$past(vec_wr_data[VEC_W-1])}}, $past(vec_wr_data[VEC_W-1:0])})); // R8

endmodule

bind rgbvc_top rgbvc_chk chk_i (.*);

// File: tb/rgbvc_top_tb_top.sv
module rgbvc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pk_wr_en = 1'b0;
    logic [31:0] pk_wr_data = '0;
    logic [2:0]  vec_wr_en = '0;
    logic [31:0] vec_wr_data = '0;
    logic [31:0] pk_in_rd, pk_out_rd, vec0_rd, vec1_rd, vec2_rd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rgbvc_top dut_i (
        .clk(clk), .rst(rst), .pk_wr_en(pk_wr_en), .pk_wr_data(pk_wr_data),
        .vec_wr_en(vec_wr_en), .vec_wr_data(vec_wr_data),
        .pk_in_rd(pk_in_rd), .pk_out_rd(pk_out_rd),
        .vec0_rd(vec0_rd), .vec1_rd(vec1_rd), .vec2_rd(vec2_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_vec(input int c);
        return 32'(c * 128);
    endfunction

    function automatic int exp_col(input int v16);
        int s, q;
        s = (v16 >= 32768) ? v16 - 65536 : v16;
        if (s < 0) return 0;
        q = s / 128;
        return (q > 31) ? 31 : q;
    endfunction

    function automatic logic [31:0] mk_pack(input int r, input int g, input int b);
        return 32'(b * 1024 + g * 32 + r);
    endfunction

    function automatic logic [31:0] sext16(input int v16);
        return (v16 >= 32768) ? 32'(v16) | 32'hFFFF0000 : 32'(v16);
    endfunction

    function automatic string clamp_tag(input int v16);
        if (v16 >= 32768) return "R4 negative";
        if (v16 >= 4096)  return "R4 high";
        return "R3 in-range";
    endfunction

    task automatic direct_all(input int v16);
        vec_wr_en   = 3'b111;
        vec_wr_data = {16'h5A5A, v16[15:0]};
        step();
        vec_wr_en   = '0;
        chk("R8 sign-extended read", vec0_rd, sext16(v16));
        chk(clamp_tag(v16), pk_out_rd, mk_pack(exp_col(v16), exp_col(v16), exp_col(v16)));
        chk("R5 in/out views", pk_in_rd, pk_out_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hist [40];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 reg0", vec0_rd, '0);
        chk("R10 reg1", vec1_rd, '0);
        chk("R10 reg2", vec2_rd, '0);
        chk("R10 packed out", pk_out_rd, '0);
        chk("R10 packed in", pk_in_rd, '0);

        // R6/R7: single write latency, upper garbage bits (R1)
        pk_wr_en   = 1'b1;
        pk_wr_data = 32'hFFFF8000 | mk_pack(31, 10, 21);
        step();                        // edge N
        pk_wr_en = 1'b0;
        chk("R6 blue old after N", vec2_rd, '0);
        chk("R7 red old after N", vec0_rd, '0);
        step();                        // N+1
        chk("R6 blue old after N+1", vec2_rd, '0);
        chk("R7 green old after N+1", vec1_rd, '0);
        step();                        // N+2
        chk("R6 blue new after N+2", vec2_rd, exp_vec(21));
        chk("R7 red old after N+2", vec0_rd, '0);
        step();                        // N+3
        chk("R7 red new", vec0_rd, exp_vec(31));
        chk("R7 green new", vec1_rd, exp_vec(10));
        chk("R1 packed layout, high bits zero", pk_out_rd, mk_pack(31, 10, 21));
        chk("R5 packed input view", pk_in_rd, mk_pack(31, 10, 21));

        // R2/R6/R7: back-to-back packed writes
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            w = (32'(k) * 32'h00A30000) | (k[0] ? 32'h8000 : 32'h0)
                | mk_pack(k & 31, (k * 5 + 3) & 31, (k * 11 + 7) & 31);
            hist[k]    = w;
            pk_wr_en   = 1'b1;
            pk_wr_data = w;
            step();
            if (k >= 2)
                chk("R6 R2 blue pipelined", vec2_rd, exp_vec(int'(hist[k-2][14:10])));
            if (k >= 3) begin
                chk("R7 R2 red pipelined", vec0_rd, exp_vec(int'(hist[k-3][4:0])));
                chk("R7 R2 green pipelined", vec1_rd, exp_vec(int'(hist[k-3][9:5])));
                chk("R5 R1 packed view pipelined", pk_in_rd,
                    mk_pack(int'(hist[k-3][4:0]), int'(hist[k-3][9:5]), int'(hist[k-2][14:10])));
            end
        end
        pk_wr_en = 1'b0;
        repeat (3) step();
        chk("R2 final red", vec0_rd, exp_vec(int'(hist[39][4:0])));
        chk("R2 final blue", vec2_rd, exp_vec(int'(hist[39][14:10])));

        // R3/R4/R8: near-exhaustive sweep of vector values
        for (int v = 0; v < 65536; v += 37) direct_all(v);
        direct_all(16'h007F); direct_all(16'h0080); direct_all(16'h0F80);
        direct_all(16'h0FFF); direct_all(16'h1000); direct_all(16'h7FFF);
        direct_all(16'h8000); direct_all(16'hFFFF); direct_all(0);

        // R8: single-register write touches only that register
        vec_wr_en   = 3'b010;
        vec_wr_data = 32'h0000_0A00;
        step();
        vec_wr_en = '0;
        chk("R8 reg1 written", vec1_rd, 32'h0000_0A00);
        chk("R8 reg0 untouched", vec0_rd, '0);
        chk("R8 reg2 untouched", vec2_rd, '0);

        // R9: direct write one edge after packed write
        pk_wr_en   = 1'b1;
        pk_wr_data = mk_pack(17, 17, 17);
        step();                        // N
        pk_wr_en    = 1'b0;
        vec_wr_en   = 3'b001;
        vec_wr_data = 32'h0000_1234;
        step();                        // N+1
        vec_wr_en = '0;
        chk("R9 direct value reg0", vec0_rd, 32'h1234);
        step();                        // N+2
        chk("R9 blue still expands", vec2_rd, exp_vec(17));
        step();                        // N+3
        chk("R9 green still expands", vec1_rd, exp_vec(17));
        chk("R9 red expansion cancelled", vec0_rd, 32'h1234);
        step();
        chk("R9 red stays direct", vec0_rd, 32'h1234);

        // R9: direct write at the same edge as the packed write
        pk_wr_en    = 1'b1;
        pk_wr_data  = mk_pack(5, 6, 31);
        vec_wr_en   = 3'b100;
        vec_wr_data = 32'h1234_F00F;
        step();
        pk_wr_en  = 1'b0;
        vec_wr_en = '0;
        chk("R9 same-edge direct wins", vec2_rd, 32'hFFFF_F00F);
        repeat (3) step();
        chk("R9 same-edge blue kept", vec2_rd, 32'hFFFF_F00F);
        chk("R9 same-edge red expands", vec0_rd, exp_vec(5));
        chk("R4 R9 packed view", pk_out_rd, mk_pack(5, 6, 0));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule